// File: doc/BRIEF.md
# Masked Register Walking-Ones Verifier

This block is a built-in self-test engine for a bank of memory-mapped registers and small tables. It works down a list of descriptors held in parameters. Each descriptor gives a base address, an entry span, a mask of the bits under test, a fixed value for read-only checks, a read-only flag and an auto-increment flag. The engine drives the registers through a single-master synchronous bus. For an ordinary register it first reads the current value, then writes and reads back a series of patterns and compares each result under the mask, and finally writes the saved value back.

Read-only registers are only read and compared against their fixed value. A table can be covered in two ways. In the first, every entry is addressed explicitly and gets the full save, test and restore treatment. In the second, the engine loads the register file's address pointer once per pass and then streams auto-incrementing accesses.

A one-cycle start pulse launches a run over the first `desc_count` descriptors. The run ends with `done`. On the first mismatch the engine stops at once, sets `fail`, and holds the failing address together with the expected and actual masked values until the next start.

Top module: `regwalk_engine`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are low and `bus_op` is 0 (idle).
- R2: A high `start` while the engine is idle raises `busy` on the next edge. `busy` stays high until the edge that raises `done`, and `busy` and `done` are never high together. `start` has no effect while `busy` is high. A `desc_count` of 0 finishes with `done` high and `fail` low.
- R3: Bus encoding on `bus_op`: 0 idle, 1 read, 2 write, 3 load pointer from `bus_addr`. Read data is sampled on `bus_rdata` in the cycle after the read is issued, and the comparison is made in that cycle.
- R4: For each writable entry, the pattern order is all zeros, then all ones, then a single one walked upward through each bit position that is set in the mask. Each pattern is written and then read back before the next one starts.
- R5: For each explicitly addressed writable entry, the first bus access is a read of that entry, and the last is a write of the value that read returned.
- R6: Bits outside the mask are written with the saved value of the entry, so they never change. A difference in those bits is never reported, even when the mask is non-contiguous (for example 0xF8FFFFFF or 0xDF).
- R7: A read-only descriptor issues no write. Each read is compared with its fixed value under the mask.
- R8: In explicit mode, each entry base+i (i = 0..span) gets the full save, walk and restore sequence.
- R9: In auto-increment mode, each pattern costs one pointer load followed by span+1 auto writes of the masked pattern, then another pointer load and span+1 auto reads. The table is left holding the final walking pattern.
- R10: The first mismatch stops the run with `done` and `fail` high. It latches the failing address, the expected masked value and the actual read value ANDed with the mask, and these hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run request, acted on only while idle |
| desc_count | input | CW | Number of descriptors to run, clamped to NDESC |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| fail | output | 1 | Run stopped on a mismatch |
| fail_addr | output | AW | Address of the failing read |
| fail_exp | output | DW | Expected value under the mask |
| fail_act | output | DW | Read value under the mask |
| bus_op | output | 2 | Bus command: 0 idle, 1 read, 2 write, 3 load pointer |
| bus_auto | output | 1 | Access uses and then increments the pointer |
| bus_addr | output | AW | Access or pointer address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid the cycle after a read |

## Verification
The bench builds the engine with a 12-bit address, 32-bit data, six descriptors and an 8-bit span. The six descriptors are: a full-width register, a register with a split mask 0xF8FFFFFF, a register with the 0xDF mask that has a hole, a read-only register expecting 0x8C, and one 256-entry table reached twice, once explicitly and once through auto-increment. These values let stuck-at faults land both inside and outside a mask hole. They also let a fault hit only streaming reads deep in the table, and they put the span at its 256-entry limit, so pointer-load counts, restore order and the final table contents all become visible at the ports.

// File: rtl/regwalk_pkg.sv
package regwalk_pkg;

   typedef enum logic [1:0] {
      OP_IDLE   = 2'd0,
      OP_READ   = 2'd1,
      OP_WRITE  = 2'd2,
      OP_SETPTR = 2'd3
   } bus_op_e;

   typedef enum logic [3:0] {
      S_IDLE,
      S_LOAD,
      S_SV_RD,
      S_SV_CK,
      S_P_WR,
      S_P_RD,
      S_P_CK,
      S_RST,
      S_ENT,
      S_RO_RD,
      S_RO_CK,
      S_A_PTR,
      S_A_WR,
      S_A_PTR2,
      S_A_RD,
      S_A_CK
   } state_e;

endpackage

// File: rtl/regwalk_desc_sel.sv
module regwalk_desc_sel #(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int NDESC = 4,
   parameter int SPW   = 8,
   parameter int IW    = 3,
   parameter logic [NDESC-1:0][AW-1:0]  D_ADDR = '0,
   parameter logic [NDESC-1:0][DW-1:0]  D_MASK = '0,
   parameter logic [NDESC-1:0][DW-1:0]  D_EXP  = '0,
   parameter logic [NDESC-1:0][SPW-1:0] D_SPAN = '0,
   parameter logic [NDESC-1:0]          D_RO   = '0,
   parameter logic [NDESC-1:0]          D_AUTO = '0
) (
   input  logic [IW-1:0]  idx,
   output logic [AW-1:0]  addr,
   output logic [DW-1:0]  mask,
   output logic [DW-1:0]  expv,
   output logic [SPW-1:0] span,
   output logic           ro,
   output logic           autoinc
);

   always_comb begin
      addr    = '0;
      mask    = '0;
      expv    = '0;
      span    = '0;
      ro      = 1'b0;
      autoinc = 1'b0;
      for (int i = 0; i < NDESC; i++) begin
         if (idx == IW'(i)) begin
            addr    = D_ADDR[i];
            mask    = D_MASK[i];
            expv    = D_EXP[i];
            span    = D_SPAN[i];
            ro      = D_RO[i];
            autoinc = D_AUTO[i];
         end
      end
   end

endmodule

// File: rtl/regwalk_patgen.sv
module regwalk_patgen #(
   parameter int DW = 32,
   parameter int PW = 6
) (
   input  logic [DW-1:0] mask,
   input  logic [PW-1:0] idx,
   output logic [DW-1:0] pat,
   output logic [PW-1:0] nxt,
   output logic          last
);

   logic found;

   always_comb begin
      if (idx == '0)
         pat = '0;
      else if (idx == PW'(1))
         pat = '1;
      else
         pat = {{(DW-1){1'b0}}, 1'b1} << (idx - PW'(2));
   end

   // smallest legal index above idx: 0 and 1 always legal, k>=2 only if mask bit k-2 set
   always_comb begin
      nxt   = '0;
      found = 1'b0;
      for (int j = DW + 1; j >= 1; j--) begin
         if ((PW'(j) > idx) && ((j < 2) ? 1'b1 : mask[(j >= 2) ? (j - 2) : 0])) begin
            nxt   = PW'(j);
            found = 1'b1;
         end
      end
      last = !found;
   end

endmodule

// File: rtl/regwalk_cmp.sv
module regwalk_cmp #(
   parameter int DW = 32
) (
   input  logic [DW-1:0] rdata,
   input  logic [DW-1:0] expv,
   input  logic [DW-1:0] mask,
   output logic [DW-1:0] act_m,
   output logic          mism
);

   assign act_m = rdata & mask;
   assign mism  = |((rdata ^ expv) & mask);

endmodule

// File: rtl/regwalk_engine.sv
module regwalk_engine #(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int NDESC = 4,
   parameter int SPW   = 8,
   parameter logic [NDESC-1:0][AW-1:0]  D_ADDR = '0,
   parameter logic [NDESC-1:0][DW-1:0]  D_MASK = '0,
   parameter logic [NDESC-1:0][DW-1:0]  D_EXP  = '0,
   parameter logic [NDESC-1:0][SPW-1:0] D_SPAN = '0,
   parameter logic [NDESC-1:0]          D_RO   = '0,
   parameter logic [NDESC-1:0]          D_AUTO = '0,
   localparam int CW = $clog2(NDESC + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] desc_count,
   output logic          busy,
   output logic          done,
   output logic          fail,
   output logic [AW-1:0] fail_addr,
   output logic [DW-1:0] fail_exp,
   output logic [DW-1:0] fail_act,
   output logic [1:0]    bus_op,
   output logic          bus_auto,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata
);
   import regwalk_pkg::*;

   localparam int PW = $clog2(DW + 2);

   generate
      if (AW < 2)     $error("regwalk_engine: AW must be at least 2");
      if (DW < 2)     $error("regwalk_engine: DW must be at least 2");
      if (NDESC < 1)  $error("regwalk_engine: NDESC must be at least 1");
      if (SPW < 1)    $error("regwalk_engine: SPW must be at least 1");
      if (SPW > AW)   $error("regwalk_engine: span cannot exceed address space");
   endgenerate

   state_e          st;
   logic [CW-1:0]   dix, lim_q, lim_in;
   logic [SPW-1:0]  ent, cnt;
   logic [PW-1:0]   pix;
   logic [DW-1:0]   saved;

   logic [AW-1:0]   d_addr;
   logic [DW-1:0]   d_mask, d_exp;
   logic [SPW-1:0]  d_span;
   logic            cur_ro, d_auto;

   logic [DW-1:0]   pat, pat_m, cmp_exp, act_m;
   logic [PW-1:0]   pnxt;
   logic            plast, mism, chk_st;
   logic [AW-1:0]   cur_addr, auto_addr, cmp_addr;
   bus_op_e         op;

   regwalk_desc_sel #(
      .AW(AW), .DW(DW), .NDESC(NDESC), .SPW(SPW), .IW(CW),
      .D_ADDR(D_ADDR), .D_MASK(D_MASK), .D_EXP(D_EXP),
      .D_SPAN(D_SPAN), .D_RO(D_RO), .D_AUTO(D_AUTO)
   ) u_desc (
      .idx(dix), .addr(d_addr), .mask(d_mask), .expv(d_exp),
      .span(d_span), .ro(cur_ro), .autoinc(d_auto)
   );

   regwalk_patgen #(.DW(DW), .PW(PW)) u_pat (
      .mask(d_mask), .idx(pix), .pat(pat), .nxt(pnxt), .last(plast)
   );

   assign pat_m     = pat & d_mask;
   assign cur_addr  = d_addr + AW'(ent);
   assign auto_addr = d_addr + AW'(cnt);
   assign cmp_exp   = (st == S_RO_CK) ? (d_exp & d_mask) : pat_m;
   assign cmp_addr  = (st == S_A_CK) ? auto_addr : cur_addr;
   assign chk_st    = (st == S_P_CK) || (st == S_RO_CK) || (st == S_A_CK);
   assign lim_in    = (desc_count > CW'(NDESC)) ? CW'(NDESC) : desc_count;

   regwalk_cmp #(.DW(DW)) u_cmp (
      .rdata(bus_rdata), .expv(cmp_exp), .mask(d_mask),
      .act_m(act_m), .mism(mism)
   );

   // bus command decode from the controller state
   always_comb begin
      op        = OP_IDLE;
      bus_auto  = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      case (st)
         S_SV_RD, S_P_RD, S_RO_RD: begin
            op       = OP_READ;
            bus_addr = cur_addr;
         end
         S_P_WR: begin
            op        = OP_WRITE;
            bus_addr  = cur_addr;
            bus_wdata = pat_m | (saved & ~d_mask);
         end
         S_RST: begin
            op        = OP_WRITE;
            bus_addr  = cur_addr;
            bus_wdata = saved;
         end
         S_A_PTR, S_A_PTR2: begin
            op       = OP_SETPTR;
            bus_addr = d_addr;
         end
         S_A_WR: begin
            op        = OP_WRITE;
            bus_auto  = 1'b1;
            bus_wdata = pat_m;
         end
         S_A_RD: begin
            op       = OP_READ;
            bus_auto = 1'b1;
         end
         default: ;
      endcase
   end

   assign bus_op = op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         dix       <= '0;
         lim_q     <= '0;
         ent       <= '0;
         cnt       <= '0;
         pix       <= '0;
         saved     <= '0;
         busy      <= 1'b0;
         done      <= 1'b0;
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_exp  <= '0;
         fail_act  <= '0;
      end else if (chk_st && mism) begin
         st        <= S_IDLE;
         busy      <= 1'b0;
         done      <= 1'b1;
         fail      <= 1'b1;
         fail_addr <= cmp_addr;
         fail_exp  <= cmp_exp;
         fail_act  <= act_m;
      end else begin
         case (st)
            S_IDLE: begin
               if (start) begin
                  done      <= 1'b0;
                  fail      <= 1'b0;
                  fail_addr <= '0;
                  fail_exp  <= '0;
                  fail_act  <= '0;
                  dix       <= '0;
                  lim_q     <= lim_in;
                  if (lim_in == '0) begin
                     done <= 1'b1;
                  end else begin
                     busy <= 1'b1;
                     st   <= S_LOAD;
                  end
               end
            end
            S_LOAD: begin
               ent <= '0;
               cnt <= '0;
               pix <= '0;
               if (cur_ro)      st <= S_RO_RD;
               else if (d_auto) st <= S_A_PTR;
               else             st <= S_SV_RD;
            end
            S_SV_RD: st <= S_SV_CK;
            S_SV_CK: begin
               saved <= bus_rdata;
               pix   <= '0;
               st    <= S_P_WR;
            end
            S_P_WR:  st <= S_P_RD;
            S_P_RD:  st <= S_P_CK;
            S_P_CK: begin
               if (plast) begin
                  st <= S_RST;
               end else begin
                  pix <= pnxt;
                  st  <= S_P_WR;
               end
            end
            S_RST:   st <= S_ENT;
            S_ENT: begin
               if (ent == d_span) begin
                  if (dix == lim_q - CW'(1)) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                     st   <= S_IDLE;
                  end else begin
                     dix <= dix + CW'(1);
                     st  <= S_LOAD;
                  end
               end else begin
                  ent <= ent + SPW'(1);
                  st  <= cur_ro ? S_RO_RD : S_SV_RD;
               end
            end
            S_RO_RD: st <= S_RO_CK;
            S_RO_CK: st <= S_ENT;
            S_A_PTR: begin
               cnt <= '0;
               st  <= S_A_WR;
            end
            S_A_WR: begin
               if (cnt == d_span) begin
                  cnt <= '0;
                  st  <= S_A_PTR2;
               end else begin
                  cnt <= cnt + SPW'(1);
               end
            end
            S_A_PTR2: st <= S_A_RD;
            S_A_RD:   st <= S_A_CK;
            S_A_CK: begin
               if (cnt == d_span) begin
                  if (plast) begin
                     ent <= d_span;
                     st  <= S_ENT;
                  end else begin
                     pix <= pnxt;
                     st  <= S_A_PTR;
                  end
               end else begin
                  cnt <= cnt + SPW'(1);
                  st  <= S_A_RD;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/regwalk_engine_chk.sv
module regwalk_engine_chk #(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          fail,
   input logic [1:0]    bus_op,
   input logic          bus_auto,
   input logic          cur_ro,
   input logic [AW-1:0] fail_addr
);

   // R2
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   // R2
   busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R3
   bus_quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (bus_op == 2'd0));

   // R7
   ro_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_op == 2'd2) |-> !cur_ro);

   // R9
   auto_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_auto |-> ((bus_op == 2'd1) || (bus_op == 2'd2)));

   // R10
   fail_means_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> done);

   // R10
   fail_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> $stable(fail_addr));

endmodule

bind regwalk_engine regwalk_engine_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .fail(fail), .bus_op(bus_op), .bus_auto(bus_auto), .cur_ro(cur_ro),
   .fail_addr(fail_addr)
);

// File: tb/regwalk_engine_test.sv
module regwalk_engine_test;

   localparam int AW = 12;
   localparam int DW = 32;
   localparam int ND = 6;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] desc_count = '0;
   logic          busy, done, fail;
   logic [AW-1:0] fail_addr, bus_addr;
   logic [DW-1:0] fail_exp, fail_act, bus_wdata;
   logic [DW-1:0] bus_rdata;
   logic [1:0]    bus_op;
   logic          bus_auto;

   always #4 clk = ~clk;

   regwalk_engine #(
      .AW(AW), .DW(DW), .NDESC(ND), .SPW(8),
      .D_ADDR({12'h100, 12'h100, 12'h00E, 12'h002, 12'h001, 12'h000}),
      .D_MASK({32'hF8FFFFFF, 32'hF8FFFFFF, 32'h000000FF, 32'h000000DF,
               32'hF8FFFFFF, 32'hFFFFFFFF}),
      .D_EXP ({32'h0, 32'h0, 32'h0000008C, 32'h0, 32'h0, 32'h0}),
      .D_SPAN({8'd255, 8'd255, 8'd0, 8'd0, 8'd0, 8'd0}),
      .D_RO  (6'b001000),
      .D_AUTO(6'b100000)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .desc_count(desc_count),
      .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
      .fail_exp(fail_exp), .fail_act(fail_act), .bus_op(bus_op),
      .bus_auto(bus_auto), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata)
   );

   // ---------------- register-file model ----------------
   logic [31:0] regs [16];
   logic [31:0] tbl  [256];
   logic [11:0] ptr;
   logic        mdl_init = 1'b0;
   logic [1:0]  fmode = 2'd0;
   logic [11:0] f_addr = '0;
   int          f_bit = 0;
   logic        ro_bad = 1'b0;
   int          ro_wr, viol, setptr_n, autowr_n, tblwr_n, wr_n, log_n;
   logic [1:0]  log_op   [6];
   logic [11:0] log_addr [6];
   logic [31:0] log_data [6];
   logic [31:0] last_wr;

   function automatic logic [31:0] raw_val(input logic [11:0] a);
      if (a[8])            return tbl[a[7:0]];
      else if (a == 12'h00E) return ro_bad ? 32'h8D : 32'h8C;
      else                 return regs[a[3:0]];
   endfunction

   function automatic logic [31:0] cmask(input logic [11:0] a);
      if (a[8] || a == 12'h001) return 32'hF8FFFFFF;
      else if (a == 12'h002)    return 32'h000000DF;
      else                      return 32'hFFFFFFFF;
   endfunction

   always @(posedge clk) begin
      logic [11:0] a;
      logic [31:0] v;
      if (mdl_init) begin
         for (int i = 0; i < 16; i++) regs[i] = 32'h11111111 * i;
         regs[0] = 32'hCAFEF00D;
         regs[1] = 32'h12345678;
         regs[2] = 32'h00000024;
         for (int i = 0; i < 256; i++)
            tbl[i] = (32'h5A000000 ^ {8'h0, i[7:0], i[7:0], i[7:0]}) & 32'hF8FFFFFF;
         ptr = '0; ro_wr = 0; viol = 0; setptr_n = 0; autowr_n = 0;
         tblwr_n = 0; wr_n = 0; log_n = 0; last_wr = '0;
      end else if (bus_op != 2'd0) begin
         a = bus_auto ? ptr : bus_addr;
         if (log_n < 6) begin
            log_op[log_n] = bus_op; log_addr[log_n] = a; log_data[log_n] = bus_wdata;
         end
         log_n = log_n + 1;
         case (bus_op)
            2'd1: begin
               v = raw_val(a);
               if (fmode != 0 && a == f_addr && (fmode != 3 || bus_auto))
                  v[f_bit] = (fmode == 1);
               bus_rdata <= v;
               if (bus_auto) ptr = ptr + 1;
            end
            2'd2: begin
               wr_n = wr_n + 1;
               last_wr = bus_wdata;
               if (!bus_auto && (((bus_wdata ^ raw_val(a)) & ~cmask(a)) != 0)) viol = viol + 1;
               if (a == 12'h00E) ro_wr = ro_wr + 1;
               else if (a[8]) tbl[a[7:0]] = bus_wdata;
               else regs[a[3:0]] = bus_wdata;
               if (a[8] && !bus_auto) tblwr_n = tblwr_n + 1;
               if (bus_auto) begin autowr_n = autowr_n + 1; ptr = ptr + 1; end
            end
            default: begin ptr = bus_addr; setptr_n = setptr_n + 1; end
         endcase
      end
   end

   // ---------------- bench bookkeeping ----------------
   int n_chk = 0;
   int n_bad = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic run(input int cnt, output int cyc, input bit extra_start);
      @(negedge clk) mdl_init = 1'b1;
      @(negedge clk) mdl_init = 1'b0;
      desc_count = CW'(cnt);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      cyc = 1;
      while (!done && cyc < 70000) begin
         @(negedge clk);
         cyc++;
         if (extra_start && cyc == 6) start = 1'b1;
         else start = 1'b0;
         if (extra_start && cyc > 1 && !done)
            check(busy, "R2 busy held during run", {31'b0, busy}, 32'd1);
      end
      start = 1'b0;
      if (!done) check(1'b0, "watchdog run did not finish", cyc, 70000);
   endtask

   typedef struct packed {
      logic [2:0]  cnt;
      logic [1:0]  fm;
      logic [11:0] fa;
      logic [4:0]  fb;
      logic        rob;
      logic        ef;
      logic [11:0] ea;
      logic [31:0] ee;
      logic [31:0] eact;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{3'd6, 2'd0, 12'h000, 5'd0,  1'b0, 1'b0, 12'h000, 32'h0,        32'h0},
      '{3'd3, 2'd1, 12'h002, 5'd3,  1'b0, 1'b1, 12'h002, 32'h0,        32'h08},
      '{3'd3, 2'd2, 12'h002, 5'd3,  1'b0, 1'b1, 12'h002, 32'hDF,       32'hD7},
      '{3'd3, 2'd1, 12'h002, 5'd5,  1'b0, 1'b0, 12'h000, 32'h0,        32'h0},
      '{3'd4, 2'd0, 12'h000, 5'd0,  1'b1, 1'b1, 12'h00E, 32'h8C,       32'h8D},
      '{3'd2, 2'd2, 12'h001, 5'd26, 1'b0, 1'b0, 12'h000, 32'h0,        32'h0},
      '{3'd5, 2'd2, 12'h137, 5'd0,  1'b0, 1'b1, 12'h137, 32'hF8FFFFFF, 32'hF8FFFFFE},
      '{3'd6, 2'd3, 12'h180, 5'd31, 1'b0, 1'b1, 12'h180, 32'hF8FFFFFF, 32'h78FFFFFF},
      '{3'd0, 2'd0, 12'h000, 5'd0,  1'b0, 1'b0, 12'h000, 32'h0,        32'h0}
   };

   initial begin
      #(8 * 195000);
      check(1'b0, "watchdog global timeout", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int cyc_a, cyc_b;
      bit tbl_ok;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !done && !fail, "R1 flags low in reset", {busy, done, fail}, 0);
      check(bus_op == 2'd0, "R1 bus idle in reset", bus_op, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !fail && bus_op == 2'd0, "R1 idle after reset",
            {busy, done, fail, bus_op}, 0);

      // vector table
      foreach (VECS[k]) begin
         fmode  = VECS[k].fm;
         f_addr = VECS[k].fa;
         f_bit  = int'(VECS[k].fb);
         ro_bad = VECS[k].rob;
         run(int'(VECS[k].cnt), cyc_a, 1'b0);
         check(done && !busy, "R2 done at end of run", {busy, done}, 32'h1);
         check(fail == VECS[k].ef, "R10 fail flag", fail, VECS[k].ef);
         if (VECS[k].ef) begin
            check(fail_addr == VECS[k].ea, "R10 failing address", fail_addr, VECS[k].ea);
            check(fail_exp == VECS[k].ee, "R10 expected value", fail_exp, VECS[k].ee);
            check(fail_act == VECS[k].eact, "R10 actual value", fail_act, VECS[k].eact);
            @(negedge clk);
            check(bus_op == 2'd0 && done, "R10 run stopped", bus_op, 0);
         end else if (VECS[k].cnt >= 3) begin
            // R5 restore
            check(regs[0] == 32'hCAFEF00D, "R5 reg0 restored", regs[0], 32'hCAFEF00D);
            check(regs[1] == 32'h12345678, "R5 reg1 restored", regs[1], 32'h12345678);
            check(regs[2] == 32'h00000024, "R6 reg2 hole bit kept", regs[2], 32'h24);
         end
         check(viol == 0, "R6 masked-out bits unchanged", viol, 0);
         check(ro_wr == 0, "R7 no write to read-only", ro_wr, 0);
         if (k == 0) begin
            tbl_ok = 1'b1;
            for (int i = 0; i < 256; i++) if (tbl[i] != 32'h80000000) tbl_ok = 1'b0;
            check(tbl_ok, "R9 table holds final pattern", tbl[255], 32'h80000000);
            check(setptr_n == 62, "R9 pointer loads", setptr_n, 62);
            check(autowr_n == 7936, "R9 auto writes", autowr_n, 7936);
            check(tblwr_n == 8192, "R8 explicit table writes", tblwr_n, 8192);
         end
         if (k == 8) check(log_n == 0, "R2 zero count issues no access", log_n, 0);
      end

      // R4/R5/R3 bus trace on the full-width register
      fmode = 2'd0; ro_bad = 1'b0;
      run(1, cyc_a, 1'b0);
      check(log_op[0] == 2'd1 && log_addr[0] == 12'h000, "R5 first access is read",
            log_op[0], 1);
      check(log_op[1] == 2'd2 && log_data[1] == 32'h0, "R4 zeros written first",
            log_data[1], 32'h0);
      check(log_op[2] == 2'd1, "R3 readback after write", log_op[2], 1);
      check(log_data[3] == 32'hFFFFFFFF, "R4 ones second", log_data[3], 32'hFFFFFFFF);
      check(log_data[5] == 32'h00000001, "R4 walk starts at bit 0", log_data[5], 32'h1);
      check(last_wr == 32'hCAFEF00D, "R5 last write restores", last_wr, 32'hCAFEF00D);
      check(wr_n == 35, "R4 pattern count full mask", wr_n, 35);

      // R2 start ignored while busy
      run(1, cyc_b, 1'b1);
      check(cyc_a == cyc_b, "R2 start ignored while busy", cyc_b, cyc_a);
      check(wr_n == 35, "R2 no second run", wr_n, 35);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule